// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block is the sending half of an asynchronous serial channel. A processor writes one byte at a time into a single-entry holding register. When the shifter is free, it takes that byte and sends a frame on `txd`. The frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop interval. Each bit lasts a fixed number of pulses (sixteen by default) of an oversampling enable, `tick16`. Clock cycles in which `tick16` is low do not count toward a bit.

The frame format is captured when a byte moves into the shifter. The format covers character length, parity mode and stop length. Changing the format inputs therefore never corrupts a character that is already on the line.

A break input pulls `txd` low at once. The sequencing keeps running as if no break were present. A character written during the break is still shifted through, takes its normal time, and is lost. Software waits for `tx_empty` and then releases the break.

Two flags report progress:
- `thr_empty` shows that the holding register can take a byte.
- `tx_empty` shows that both the holding register and the shifter are idle.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `thr_empty` is 1 and `tx_empty` is 1.
- R2: Frame shape when the line is idle:
  - `txd` sits at 1 while the line is idle.
  - A frame is a 0 start bit, the data bits least significant first, the optional parity bit, then the stop interval at 1.
  - Each start, data and parity bit lasts 16 `tick16` pulses.
  - The start bit begins on the clock edge that moves the byte into the shifter.
- R3: `len_code` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Unused upper bits of `wr_data` are not sent.
- R4: `par_cfg` selects parity as follows:
  - 3'b111 sends a parity bit of 0.
  - 3'b101 sends a parity bit of 1.
  - 3'b011 sends a bit that makes the count of ones among the data and parity bits even.
  - 3'b001 sends a bit that makes that count odd.
  - Any value with bit 0 clear sends no parity bit.
- R5: The stop interval lasts 16 ticks when `stop_sel` is 0. When `stop_sel` is 1 it lasts 32 ticks, or 24 ticks when the character length is 5.
- R6: `thr_empty` behaves as follows:
  - It is 0 from the edge that samples `wr_en` until the edge that moves the byte into the shifter, where it returns to 1.
  - With the shifter idle, that move happens on the edge after the write.
- R7: `tx_empty` is 1 only when the holding register and the shifter are both empty. It rises on the edge that ends the last stop interval.
- R8: A byte that waits in the holding register while a frame is being sent starts its start bit on the same edge that ends the previous stop interval, with no idle cycle between the frames.
- R9: Break behaviour:
  - While `brk_en` is 1, `txd` is 0 in the same cycle.
  - Frame timing, `thr_empty` and `tx_empty` behave exactly as without break.
  - A byte sent during the break never appears on the line.
- R10: A cycle with `tick16` low does not advance bit timing. With one tick every third clock, the start bit lasts 46 to 48 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit |
| wr_en | input | 1 | Loads `wr_data` into the holding register |
| wr_data | input | 8 | Byte to send |
| len_code | input | 2 | Character length select |
| par_cfg | input | 3 | Parity mode: {force, select, enable} |
| stop_sel | input | 1 | Long stop interval select |
| brk_en | input | 1 | Forces the line low |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
A wrong bit index, shift register or latched parity value shows up on `txd` within 16 ticks of the bit it affects. The bench therefore compares the line every clock across whole frames. A bad tick counter or stop limit moves the rise of `tx_empty` and the next start bit by whole ticks, and these are checked on the exact edge. A stuck holding flag appears at `thr_empty` one cycle after a write or after a load. A break gate that reaches into the sequencer appears as a shifted `tx_empty` edge, even though the line itself is only low.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Index of the last data bit for a length code (5..8 bits).
  function automatic logic [2:0] top_index(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // Keeps only the bits that the length code sends.
  function automatic logic [DW-1:0] len_mask(input logic [1:0] code);
    return {DW{1'b1}} >> (2'd3 - code);
  endfunction

  // cfg = {force, select, enable}
  function automatic logic parity_of(input logic [DW-1:0] d,
                                     input logic [1:0] code,
                                     input logic [2:0] cfg);
    logic [DW-1:0] m;
    m = d & len_mask(code);
    if (cfg[2]) return ~cfg[1];
    else if (cfg[1]) return ^m;
    else return ~^m;
  endfunction

  // Stop interval length in ticks.
  function automatic int stop_ticks(input logic [1:0] code, input logic sel,
                                    input int ovs);
    if (!sel) return ovs;
    if (code == 2'b00) return ovs + ovs / 2;
    return 2 * ovs;
  endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg
  import sertx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      data <= wr_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/sertx_bitclock.sv
module sertx_bitclock #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             bit_end
);

  logic [CNT_W-1:0] cnt;

  assign bit_end = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run && tick) begin
      if (bit_end) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_full,
  input  logic [DW-1:0]    hold_data,
  input  logic [1:0]       len_code,
  input  logic [2:0]       par_cfg,
  input  logic             stop_sel,
  input  logic             bit_end,
  output logic             load_ev,
  output logic             char_done,
  output logic             busy,
  output logic             line,
  output logic [CNT_W-1:0] limit
);

  tx_state_e        state;
  logic [DW-1:0]    sh;
  logic [2:0]       idx;
  logic [2:0]       last_q;
  logic             par_q;
  logic             par_en_q;
  logic [CNT_W-1:0] stop_lim_q;

  assign char_done = (state == ST_STOP) && bit_end;
  assign load_ev   = hold_full && ((state == ST_IDLE) || char_done);
  assign busy      = (state != ST_IDLE);
  assign limit     = (state == ST_STOP) ? stop_lim_q : CNT_W'(OVS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      line       <= 1'b1;
      sh         <= '0;
      idx        <= '0;
      last_q     <= '0;
      par_q      <= 1'b0;
      par_en_q   <= 1'b0;
      stop_lim_q <= CNT_W'(OVS);
    end else if (load_ev) begin
      state      <= ST_START;
      line       <= 1'b0;
      sh         <= hold_data;
      idx        <= '0;
      last_q     <= top_index(len_code);
      par_q      <= parity_of(hold_data, len_code, par_cfg);
      par_en_q   <= par_cfg[0];
      stop_lim_q <= CNT_W'(stop_ticks(len_code, stop_sel, OVS));
    end else if (bit_end) begin
      case (state)
        ST_START: begin
          state <= ST_DATA;
          line  <= sh[0];
          sh    <= sh >> 1;
          idx   <= '0;
        end
        ST_DATA: begin
          if (idx == last_q) begin
            if (par_en_q) begin
              state <= ST_PAR;
              line  <= par_q;
            end else begin
              state <= ST_STOP;
              line  <= 1'b1;
            end
          end else begin
            idx  <= idx + 1'b1;
            line <= sh[0];
            sh   <= sh >> 1;
          end
        end
        ST_PAR: begin
          state <= ST_STOP;
          line  <= 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          line  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    len_code,
  input  logic [2:0]    par_cfg,
  input  logic          stop_sel,
  input  logic          brk_en,
  output logic          txd,
  output logic          thr_empty,
  output logic          tx_empty
);

  localparam int CNT_W = $clog2(2 * OVS + 1);

  logic             hold_full;
  logic [DW-1:0]    hold_data;
  logic             load_ev;
  logic             char_done;
  logic             busy;
  logic             line;
  logic             bit_end;
  logic [CNT_W-1:0] limit;

  sertx_holdreg u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load_ev),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_bitclock #(.CNT_W(CNT_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .tick    (tick16),
    .limit   (limit),
    .bit_end (bit_end)
  );

  sertx_framer #(.OVS(OVS), .CNT_W(CNT_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .len_code  (len_code),
    .par_cfg   (par_cfg),
    .stop_sel  (stop_sel),
    .bit_end   (bit_end),
    .load_ev   (load_ev),
    .char_done (char_done),
    .busy      (busy),
    .line      (line),
    .limit     (limit)
  );

  // Break gates only the pin; sequencing is untouched.
  assign txd       = line & ~brk_en;
  assign thr_empty = ~hold_full;
  assign tx_empty  = ~hold_full & ~busy;

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic brk_en,
  input logic txd,
  input logic thr_empty,
  input logic tx_empty,
  input logic load_ev,
  input logic char_done
);

  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_en |-> !txd);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk_en) |-> txd);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !txd);

  // R7
  temt_needs_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);

  // R6
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty);

  // R6
  thre_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_empty) |-> $past(load_ev));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !load_ev) |=> (tx_empty == thr_empty));

endmodule

bind sertx_core sertx_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .brk_en    (brk_en),
  .txd       (txd),
  .thr_empty (thr_empty),
  .tx_empty  (tx_empty),
  .load_ev   (load_ev),
  .char_done (char_done)
);

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] len_code = 2'b11;
  logic [2:0] par_cfg = 3'b000;
  logic       stop_sel = 1'b0;
  logic       brk_en = 1'b0;
  logic       txd, thr_empty, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_per = 1;
  int phase = 0;
  logic exp_q[$];
  logic thr_log[$];
  logic temt_log[$];

  always #10 clk = ~clk;

  always @(posedge clk) phase <= (phase + 1 >= tick_per) ? 0 : phase + 1;
  assign tick16 = (phase == 0);

  sertx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
    .wr_data(wr_data), .len_code(len_code), .par_cfg(par_cfg),
    .stop_sel(stop_sel), .brk_en(brk_en), .txd(txd),
    .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected line value for every clock of one frame (tick every clock).
  task automatic push_frame(input logic [7:0] d, input logic blank);
    int n;
    int ones;
    int stop_t;
    logic pb;
    n = 5 + int'(len_code);
    ones = $countones(d & 8'((1 << n) - 1));
    case (par_cfg)
      3'b111:  pb = 1'b0;
      3'b101:  pb = 1'b1;
      3'b011:  pb = (ones % 2 == 1);
      3'b001:  pb = (ones % 2 == 0);
      default: pb = 1'b0;
    endcase
    stop_t = !stop_sel ? 16 : ((n == 5) ? 24 : 32);
    repeat (16) exp_q.push_back(1'b0);
    for (int b = 0; b < n; b++) repeat (16) exp_q.push_back(blank ? 1'b0 : d[b]);
    if (par_cfg[0]) repeat (16) exp_q.push_back(blank ? 1'b0 : pb);
    repeat (stop_t) exp_q.push_back(blank ? 1'b0 : 1'b1);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Starts at the negedge after the write edge; compares every clock.
  task automatic play(input string req, input int wr_at, input logic [7:0] wr_b,
                      input logic idle_val);
    int bad = 0;
    int first = -1;
    int fa = 0;
    int fe = 0;
    int last;
    thr_log.delete();
    temt_log.delete();
    for (int i = 0; i < exp_q.size(); i++) begin
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      if (txd !== exp_q[i]) begin
        if (bad == 0) begin
          first = i; fa = int'(txd); fe = int'(exp_q[i]);
        end
        bad++;
      end
      thr_log.push_back(thr_empty);
      temt_log.push_back(tx_empty);
      if (i == wr_at) begin
        wr_en = 1'b1;
        wr_data = wr_b;
      end
    end
    check(bad == 0, req, $sformatf("txd waveform first bad cycle %0d", first), fa, fe);
    last = temt_log.size() - 1;
    check(temt_log[last] == 1'b0, "R7", "tx_empty during last stop cycle",
          int'(temt_log[last]), 0);
    @(posedge clk);
    @(negedge clk);
    check(tx_empty == 1'b1, "R7", "tx_empty after stop", int'(tx_empty), 1);
    check(txd == idle_val, "R2", "line after frame", int'(txd), int'(idle_val));
    exp_q.delete();
  endtask

  task automatic t_reset();
    check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(thr_empty == 1'b1, "R1", "thr_empty after reset", int'(thr_empty), 1);
    check(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
  endtask

  task automatic t_basic();
    len_code = 2'b11; par_cfg = 3'b000; stop_sel = 1'b0;
    send(8'hA5);
    check(thr_empty == 1'b0, "R6", "thr_empty after write", int'(thr_empty), 0);
    check(tx_empty == 1'b0, "R7", "tx_empty after write", int'(tx_empty), 0);
    push_frame(8'hA5, 1'b0);
    play("R2", -1, 8'h00, 1'b1);
    check(thr_log[0] == 1'b1, "R6", "thr_empty after load edge", int'(thr_log[0]), 1);
  endtask

  task automatic t_lengths();
    par_cfg = 3'b000; stop_sel = 1'b0;
    for (int c = 0; c < 3; c++) begin
      len_code = 2'(c);
      send(8'hD6);
      push_frame(8'hD6, 1'b0);
      play($sformatf("R3 len_code=%0d", c), -1, 8'h00, 1'b1);
    end
  endtask

  task automatic t_parity();
    logic [2:0] cfgs[5] = '{3'b111, 3'b101, 3'b011, 3'b001, 3'b110};
    stop_sel = 1'b0;
    for (int k = 0; k < 5; k++) begin
      par_cfg = cfgs[k];
      len_code = 2'b10;
      send(8'h5B);
      push_frame(8'h5B, 1'b0);
      play($sformatf("R4 cfg=%0b odd-ones", cfgs[k]), -1, 8'h00, 1'b1);
      len_code = 2'b11;
      send(8'h3C);
      push_frame(8'h3C, 1'b0);
      play($sformatf("R4 cfg=%0b even-ones", cfgs[k]), -1, 8'h00, 1'b1);
    end
    par_cfg = 3'b000;
  endtask

  task automatic t_stop();
    stop_sel = 1'b1; par_cfg = 3'b011;
    len_code = 2'b11;
    send(8'h81);
    push_frame(8'h81, 1'b0);
    play("R5 two stops", -1, 8'h00, 1'b1);
    len_code = 2'b00;
    send(8'h13);
    push_frame(8'h13, 1'b0);
    play("R5 one and a half stops", -1, 8'h00, 1'b1);
    stop_sel = 1'b0; par_cfg = 3'b000; len_code = 2'b11;
  endtask

  task automatic t_b2b();
    int tot_a;
    len_code = 2'b11; par_cfg = 3'b000; stop_sel = 1'b0;
    send(8'h0F);
    push_frame(8'h0F, 1'b0);
    tot_a = exp_q.size();
    push_frame(8'hF0, 1'b0);
    play("R8", 20, 8'hF0, 1'b1);
    check(thr_log[21] == 1'b0, "R6", "thr_empty after mid-frame write", int'(thr_log[21]), 0);
    check(thr_log[tot_a-1] == 1'b0, "R8", "thr_empty before reload", int'(thr_log[tot_a-1]), 0);
    check(thr_log[tot_a] == 1'b1, "R8", "thr_empty at reload edge", int'(thr_log[tot_a]), 1);
    check(temt_log[tot_a] == 1'b0, "R8", "tx_empty across reload", int'(temt_log[tot_a]), 0);
  endtask

  task automatic t_break();
    len_code = 2'b11; par_cfg = 3'b001; stop_sel = 1'b0;
    @(negedge clk);
    brk_en = 1'b1;
    #1;
    check(txd == 1'b0, "R9", "txd same cycle as break", int'(txd), 0);
    send(8'h55);
    check(thr_empty == 1'b0, "R9", "thr_empty under break", int'(thr_empty), 0);
    push_frame(8'h55, 1'b1);
    play("R9", -1, 8'h00, 1'b0);
    @(negedge clk);
    brk_en = 1'b0;
    #1;
    check(txd == 1'b1, "R9", "line after break release", int'(txd), 1);
    check(tx_empty == 1'b1, "R9", "word lost, shifter idle", int'(tx_empty), 1);
    par_cfg = 3'b000;
  endtask

  task automatic t_slow_tick();
    int cnt = 0;
    len_code = 2'b11; par_cfg = 3'b000; stop_sel = 1'b0;
    tick_per = 3;
    send(8'hFF);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (txd == 1'b1) break;
    end
    check(cnt >= 46 && cnt <= 48, "R10", "start bit clocks at 1/3 tick", cnt, 47);
    for (int i = 0; i < 2000; i++) begin
      if (tx_empty) break;
      @(negedge clk);
    end
    check(tx_empty == 1'b1, "R10", "frame completes at slow tick", int'(tx_empty), 1);
    tick_per = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stop();
    t_b2b();
    t_break();
    t_slow_tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule